// File: doc/BRIEF.md
# Exception Entry Status Controller

This block owns the processor's current status word and performs the status-register side of taking an exception. Six event requests come in: a reset request, a memory access violation, a fast interrupt, a normal interrupt, an undefined instruction and a software-interrupt instruction. In any cycle, the block masks the two interrupt requests using the status word's own disable bits and picks the event with the highest priority. It then chooses the target processor mode for that event.

On the clock edge after an event is accepted, several things happen together. The old status word goes out with a one-hot write strobe that selects the target mode's saved-status slot in the register file. The current status word is rewritten with the new mode and updated disable bits. A vector address and a link value are presented for the fetch unit and the banked link register, and a one-cycle "taken" pulse reports the chosen mode. When no event is accepted, software can overwrite the status word through a write port. The register storage and the pipeline flush belong to neighbouring blocks.

The status word has fixed fields. Bits 31..28 are the condition flags (negative, zero, carry, overflow). Bit 7 disables the normal interrupt and bit 6 disables the fast interrupt. Bit 5 selects the compact instruction state when it is 1 and the 32-bit state when it is 0. Bits 4..0 hold the mode. Bits 27..8 always read 0. The mode codes are: user 10000, fast-interrupt 10001, normal-interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `status` equals 0x000000D3 (supervisor mode, both disable bits 1, compact bit 0, flags 0), and `taken`, `saved_we` and `link_we` are 0.
- R2: A normal interrupt request is ignored while status bit 7 is 1, and a fast interrupt request is ignored while status bit 6 is 1. Each is accepted when its bit is 0.
- R3: Each accepted event sets `taken_mode` and the new status mode to its target mode, and sets `vector` to VEC_BASE plus an offset. The pairs are: reset request to supervisor at 0x00, undefined to undefined at 0x04, software interrupt to supervisor at 0x08, abort to abort at 0x0C, normal interrupt to normal-interrupt at 0x18, and fast interrupt to fast-interrupt at 0x1C.
- R4: When several acceptable events occur in one cycle, the winner is chosen in this order: reset request, abort, fast interrupt, normal interrupt, undefined, software interrupt.
- R5: On any accepted event, bit 7 becomes 1 and bit 5 becomes 0. Bit 6 becomes 1 on a reset request or a fast interrupt and is otherwise unchanged. The flags are kept, except on a reset request.
- R6: On a non-reset entry, `saved_we` is one-hot and `saved_data` is the status word from before the entry. The strobe bits are 0 for fast-interrupt, 1 for normal-interrupt, 2 for supervisor, 3 for abort and 4 for undefined. On a reset request, `saved_we` stays 0 and the flags are cleared.
- R7: On a non-reset entry, `link_we` is 1 and `link_data` equals the event cycle's `pc_in` plus LINK_OFS (default 4). On a reset request, `link_we` is 0.
- R8: All results appear one clock edge after the event cycle. `taken` is high for exactly those cycles that follow a cycle with an accepted event, and low otherwise.
- R9: When `sw_we` is 1 and no event is accepted, `status` takes `sw_data` with bits 27..8 forced to 0. When an event is accepted in the same cycle, that event wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_reset | input | 1 | Reset request event |
| ev_abort | input | 1 | Memory access violation |
| ev_fiq | input | 1 | Fast interrupt request |
| ev_irq | input | 1 | Normal interrupt request |
| ev_undef | input | 1 | Undefined instruction |
| ev_swi | input | 1 | Software-interrupt instruction |
| pc_in | input | AW | Address used to form the link value |
| sw_we | input | 1 | Software status write enable |
| sw_data | input | 32 | Software status write data |
| status | output | 32 | Current status word |
| taken | output | 1 | One-cycle exception-taken pulse |
| taken_mode | output | 5 | Mode entered by the taken exception |
| vector | output | AW | Exception vector address |
| saved_we | output | 5 | One-hot saved-status write strobes |
| saved_data | output | 32 | Status word to save |
| link_we | output | 1 | Banked link register write strobe |
| link_data | output | AW | Link value |

## Verification
Every cycle, the assertions check the following:
- Masked interrupts never cause an entry.
- The mode in the status word matches `taken_mode`.
- Entry sets the normal disable bit and clears the compact bit.
- Saved data equals the previous status word, and the save strobes are at most one-hot.
- A reset entry neither saves nor links and clears the flags.
- The link value tracks `pc_in`, and an uncontested software write lands masked.

Some behaviours can only be shown by the bench's scenarios against its reference model. These are the complete priority order across simultaneous requests, the exact vector offsets per event, and the sequences in which software first unmasks an interrupt and the request is then accepted.

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter int LINK_OFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_reset,
  input  logic          ev_abort,
  input  logic          ev_fiq,
  input  logic          ev_irq,
  input  logic          ev_undef,
  input  logic          ev_swi,
  input  logic [AW-1:0] pc_in,
  input  logic          sw_we,
  input  logic [31:0]   sw_data,
  output logic [31:0]   status,
  output logic          taken,
  output logic [4:0]    taken_mode,
  output logic [AW-1:0] vector,
  output logic [4:0]    saved_we,
  output logic [31:0]   saved_data,
  output logic          link_we,
  output logic [AW-1:0] link_data
);
  localparam logic [4:0]  M_FIQ = 5'b10001;
  localparam logic [4:0]  M_IRQ = 5'b10010;
  localparam logic [4:0]  M_SVC = 5'b10011;
  localparam logic [4:0]  M_ABT = 5'b10111;
  localparam logic [4:0]  M_UND = 5'b11011;
  localparam logic [31:0] DEF_MASK = 32'hF00000FF;
  localparam logic [31:0] RST_STAT = {24'h0, 1'b1, 1'b1, 1'b0, M_SVC};

  wire irq_ok = ev_irq & ~status[7];
  wire fiq_ok = ev_fiq & ~status[6];

  logic       take, is_rst, is_fiq;
  logic [4:0] mode;
  logic [2:0] slot;
  logic [7:0] vofs;

  always_comb begin
    take = 1'b1; is_rst = 1'b0; is_fiq = 1'b0;
    mode = M_SVC; slot = 3'd2; vofs = 8'h00;
    if (ev_reset) begin
      is_rst = 1'b1;
    end else if (ev_abort) begin
      mode = M_ABT; slot = 3'd3; vofs = 8'h0C;
    end else if (fiq_ok) begin
      mode = M_FIQ; slot = 3'd0; vofs = 8'h1C; is_fiq = 1'b1;
    end else if (irq_ok) begin
      mode = M_IRQ; slot = 3'd1; vofs = 8'h18;
    end else if (ev_undef) begin
      mode = M_UND; slot = 3'd4; vofs = 8'h04;
    end else if (ev_swi) begin
      vofs = 8'h08;
    end else begin
      take = 1'b0;
    end
  end

  wire [31:0] nxt_stat = is_rst ? RST_STAT
                       : {status[31:8], 1'b1, status[6] | is_fiq, 1'b0, mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= RST_STAT;
      taken      <= 1'b0;
      taken_mode <= M_SVC;
      vector     <= '0;
      saved_we   <= '0;
      saved_data <= '0;
      link_we    <= 1'b0;
      link_data  <= '0;
    end else begin
      taken      <= take;
      taken_mode <= mode;
      vector     <= VEC_BASE + AW'(vofs);
      saved_we   <= (take && !is_rst) ? (5'd1 << slot) : 5'd0;
      saved_data <= status;
      link_we    <= take && !is_rst;
      link_data  <= pc_in + AW'(LINK_OFS);
      if (take)       status <= nxt_stat;
      else if (sw_we) status <= sw_data & DEF_MASK;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_reset,
  input logic        ev_abort,
  input logic        ev_fiq,
  input logic        ev_irq,
  input logic        ev_undef,
  input logic        ev_swi,
  input logic [31:0] pc_in,
  input logic        sw_we,
  input logic [31:0] sw_data,
  input logic [31:0] status,
  input logic        taken,
  input logic [4:0]  taken_mode,
  input logic [4:0]  saved_we,
  input logic [31:0] saved_data,
  input logic        link_we,
  input logic [31:0] link_data
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_irq && status[7] && !ev_reset && !ev_abort && !ev_fiq && !ev_undef && !ev_swi) |=> !taken); // R2
  AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fiq && status[6] && !ev_reset && !ev_abort && !ev_irq && !ev_undef && !ev_swi) |=> !taken); // R2
  AST_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> status[4:0] == taken_mode); // R3
  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (status[7] && !status[5])); // R5
  AST_SAVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(saved_we)); // R6
  AST_SAVE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && saved_we != 5'd0) |-> saved_data == $past(status)); // R6
  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !link_we) |-> (saved_we == 5'd0 && status[31:28] == 4'd0)); // R6
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_data == $past(pc_in) + 32'd4); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_reset && !ev_abort && !ev_fiq && !ev_irq && !ev_undef && !ev_swi) |=> !taken); // R8
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !ev_reset && !ev_abort && !ev_fiq && !ev_irq && !ev_undef && !ev_swi)
      |=> status == ($past(sw_data) & 32'hF00000FF)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[27:8] == 20'd0); // R9
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_reset(ev_reset), .ev_abort(ev_abort),
  .ev_fiq(ev_fiq), .ev_irq(ev_irq), .ev_undef(ev_undef), .ev_swi(ev_swi),
  .pc_in(pc_in), .sw_we(sw_we), .sw_data(sw_data), .status(status),
  .taken(taken), .taken_mode(taken_mode), .saved_we(saved_we),
  .saved_data(saved_data), .link_we(link_we), .link_data(link_data)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_reset = 0, ev_abort = 0, ev_fiq = 0, ev_irq = 0, ev_undef = 0, ev_swi = 0;
  logic [31:0] pc_in = '0, sw_data = '0;
  logic sw_we = 0;
  logic [31:0] status, vector, saved_data, link_data;
  logic taken, link_we;
  logic [4:0] taken_mode, saved_we;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model = 32'h000000D3;

  always #5 clk = ~clk;

  trap_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ev_reset(ev_reset), .ev_abort(ev_abort),
    .ev_fiq(ev_fiq), .ev_irq(ev_irq), .ev_undef(ev_undef), .ev_swi(ev_swi),
    .pc_in(pc_in), .sw_we(sw_we), .sw_data(sw_data), .status(status),
    .taken(taken), .taken_mode(taken_mode), .vector(vector),
    .saved_we(saved_we), .saved_data(saved_data), .link_we(link_we),
    .link_data(link_data));

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // event code: 0 none,1 reset,2 abort,3 fiq,4 irq,5 undef,6 swi
  function automatic int winner(input logic [31:0] s, input logic [5:0] ev);
    if (ev[0]) return 1;
    if (ev[1]) return 2;
    if (ev[2] && !s[6]) return 3;
    if (ev[3] && !s[7]) return 4;
    if (ev[4]) return 5;
    if (ev[5]) return 6;
    return 0;
  endfunction

  // ev bits: 0 reset,1 abort,2 fiq,3 irq,4 undef,5 swi
  task automatic step(input logic [5:0] ev, input logic we, input logic [31:0] wd,
                      input logic [31:0] pc, input string tag);
    int w;
    logic [4:0] m; logic [7:0] vo; int sl; logic [31:0] nx;
    {ev_swi, ev_undef, ev_irq, ev_fiq, ev_abort, ev_reset} = ev;
    sw_we = we; sw_data = wd; pc_in = pc;
    w = winner(model, ev);
    case (w)
      1: begin m = 5'b10011; vo = 8'h00; sl = -1; end
      2: begin m = 5'b10111; vo = 8'h0C; sl = 3; end
      3: begin m = 5'b10001; vo = 8'h1C; sl = 0; end
      4: begin m = 5'b10010; vo = 8'h18; sl = 1; end
      5: begin m = 5'b11011; vo = 8'h04; sl = 4; end
      default: begin m = 5'b10011; vo = 8'h08; sl = 2; end
    endcase
    if (w == 1) nx = 32'h000000D3;
    else if (w != 0) begin
      nx = model;
      nx[7] = 1'b1; nx[5] = 1'b0; nx[4:0] = m;
      if (w == 3) nx[6] = 1'b1;
    end else if (we) nx = wd & 32'hF00000FF;
    else nx = model;
    @(negedge clk);
    chk(tag, "taken", {31'd0, taken}, {31'd0, w != 0});
    chk(we ? "R9" : "R5", "status", status, nx);
    if (w != 0) begin
      chk(tag, "mode", {27'd0, taken_mode}, {27'd0, m});
      chk("R3", "vector", vector, {24'd0, vo});
      chk("R6", "saved_we", {27'd0, saved_we}, (sl < 0) ? 32'd0 : (32'd1 << sl));
      if (sl >= 0) chk("R6", "saved_data", saved_data, model);
      chk("R7", "link_we", {31'd0, link_we}, {31'd0, w != 1});
      if (w != 1) chk("R7", "link_data", link_data, pc + 32'd4);
    end else begin
      chk("R8", "saved_we idle", {27'd0, saved_we}, 32'd0);
    end
    model = nx;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", status, 32'h000000D3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "status after reset", status, 32'h000000D3);
    chk("R1", "taken after reset", {31'd0, taken}, 32'd0);
    chk("R1", "link_we after reset", {31'd0, link_we}, 32'd0);

    // R2: masked at reset state
    step(6'b001100, 0, 0, 32'h100, "R2");
    step(6'b000000, 1, 32'hA0000010, 0, "R9");
    step(6'b001000, 0, 0, 32'h200, "R3");       // irq accepted
    step(6'b000000, 1, 32'h00000090, 0, "R9");  // I=1, F=0
    step(6'b001000, 0, 0, 32'h300, "R2");       // irq ignored
    step(6'b000100, 0, 0, 32'h340, "R3");       // fiq accepted
    step(6'b000000, 1, 32'h00000050, 0, "R9");  // F=1, I=0
    step(6'b000100, 0, 0, 32'h380, "R2");       // fiq ignored
    step(6'b000000, 1, 32'h30000010, 0, "R9");
    step(6'b111111, 0, 0, 32'h400, "R4");       // reset wins
    step(6'b000000, 1, 32'h00000010, 0, "R9");
    step(6'b111110, 0, 0, 32'h500, "R4");       // abort wins
    step(6'b000000, 1, 32'h00000010, 0, "R9");
    step(6'b111100, 0, 0, 32'h600, "R4");       // fiq wins
    step(6'b000000, 1, 32'h00000010, 0, "R9");
    step(6'b111000, 0, 0, 32'h700, "R4");       // irq wins
    step(6'b110000, 0, 0, 32'h800, "R4");       // undef over swi
    step(6'b100000, 0, 0, 32'h900, "R3");       // swi
    step(6'b010000, 1, 32'h00000010, 32'hA00, "R9"); // event beats write
    step(6'b000000, 1, 32'hF00000F0, 0, "R9");
    step(6'b000001, 0, 0, 32'hB00, "R6");       // reset: no save, flags clear

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ev; logic we; logic [31:0] wd;
      ev = '0;
      for (int b = 0; b < 6; b++) ev[b] = ($urandom % 8) == 0;
      if (($urandom % 4) != 0) ev[0] = 1'b0;
      we = ($urandom % 3) == 0;
      wd = $urandom;
      wd[4:0] = (($urandom % 2) == 0) ? 5'b10000 : 5'b11111;
      step(ev, we, wd, $urandom & 32'hFFFFFFFC, "R8");
    end

    {ev_swi, ev_undef, ev_irq, ev_fiq, ev_abort, ev_reset} = '0;
    sw_we = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule